// File: doc/BRIEF.md
# Drift-Trimmed Nanosecond Time Counter

This block keeps a 64-bit nanosecond time-of-day value for a precision time protocol clock. Each clock cycle the counter advances by a fixed nominal step, `NOM_STEP` nanoseconds. A trim rule speeds the clock up or slows it down. Once per programmed interval of nominal time, the step on that one cycle is raised or lowered by a small magnitude. Software drives the block through a simple register port. Through that port it can freeze the counter, overwrite either 32-bit half while frozen, and release it. It can also program the trim word behind a hold bit and read the time as two consistent 32-bit halves.

Two state machines run the block. The run controller has the states RUNNING and FROZEN. A pause command takes RUNNING to FROZEN, a resume command takes FROZEN to RUNNING, and every other command leaves the state as it is. The trim unit has three states:
- TRIM_OFF: no correction is applied.
- TRIM_HELD: the hold bit is set.
- TRIM_ACTIVE: corrections are being applied.

Writing hold = 1 moves TRIM_OFF or TRIM_ACTIVE to TRIM_HELD. Writing hold = 0 in TRIM_HELD moves to TRIM_ACTIVE when the trim word is enabled, and to TRIM_OFF when it is not. A hold write of 1 in TRIM_HELD, or of 0 outside it, leaves the state unchanged. `NOM_STEP` must divide 8 and must be larger than 7, so the default is 8.

Top module: `tsc_drift_clock`

Register addresses:

| Address | Register | Access |
|---|---|---|
| 0 | CONTROL | read and write |
| 1 | LOAD_LOW | write |
| 2 | LOAD_HIGH | write |
| 3 | TRIM_WORD | read and write |
| 4 | TRIM_HOLD | read and write |
| 5 | TIME_LOW | read |
| 6 | TIME_HIGH | read |

Any other address reads as 0. Every write takes effect at the clock edge that samples it.

## Requirements
- R1: After reset the time value is 0 and the counter is running. CONTROL reads 0, TRIM_WORD reads 0 and TRIM_HOLD reads 0.
- R2: While running, with no correction due, the time grows by exactly `NOM_STEP` each clock cycle.
- R3: Writing 2 to CONTROL freezes the counter and writing 4 releases it. Any other value is ignored. CONTROL bit 0 reads 1 while frozen, and a frozen time value does not change.
- R4: While frozen, a write to LOAD_LOW replaces time bits 31:0 and a write to LOAD_HIGH replaces bits 63:32. While running, both writes are ignored.
- R5: The TRIM_WORD layout is as follows. Bits 27:0 hold the period P, in 16 ns units. Bits 30:28 hold the magnitude V, in ns. Bit 31 is the direction, where 1 adds and 0 subtracts. A write to TRIM_WORD is accepted only while TRIM_HOLD is 1, and is otherwise ignored. The word reads back as stored.
- R6: TRIM_HOLD bit 0 reads back the hold state. While the hold is 1, no correction is applied, and the interval count restarts from zero when the hold is released.
- R7: With trim active, a correction falls due once every 16*P+8 ns of elapsed nominal time. On that cycle the step becomes `NOM_STEP`+V or `NOM_STEP`-V. Over any run of whole intervals, the counter therefore gains or loses exactly V ns per interval.
- R8: A magnitude of 0, or a period of all ones (0xFFFFFFF), disables the trim. Writing 0 to both TRIM_WORD and TRIM_HOLD leaves the counter stepping at the nominal rate.
- R9: Reading TIME_LOW with `rd_en` set returns the live low word and captures the high word. TIME_HIGH returns the captured word, even after a later carry into the high word.
- R10: While frozen, the trim interval does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Read strobe; with TIME_LOW it captures the high word |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |

## Verification
The assertions take the following for granted:
- The single write port delivers at most one register write per cycle.
- Load writes matter only while the counter is frozen.
- `NOM_STEP` exceeds the largest magnitude, so a corrected step can never go negative.

The stimulus issues one write at a time through a task, and changes inputs one time unit after the rising edge. It programs the trim word only inside a hold window, and keeps the default step. The reference model in the bench tracks the time value, the captured high word, the frozen flag, the trim word, the hold bit and the elapsed nominal time. It checks the read port against that model on every falling edge.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CONTROL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_LOAD_LOW  = 3'd1;
    localparam logic [ADDR_W-1:0] A_LOAD_HIGH = 3'd2;
    localparam logic [ADDR_W-1:0] A_TRIM_WORD = 3'd3;
    localparam logic [ADDR_W-1:0] A_TRIM_HOLD = 3'd4;
    localparam logic [ADDR_W-1:0] A_TIME_LOW  = 3'd5;
    localparam logic [ADDR_W-1:0] A_TIME_HIGH = 3'd6;

    localparam logic [31:0] CMD_PAUSE  = 32'd2;
    localparam logic [31:0] CMD_RESUME = 32'd4;

    typedef enum logic {
        RUNNING = 1'b0,
        FROZEN  = 1'b1
    } run_state_e;

    typedef enum logic [1:0] {
        TRIM_OFF    = 2'd0,
        TRIM_HELD   = 2'd1,
        TRIM_ACTIVE = 2'd2
    } trim_state_e;
endpackage

// File: rtl/tsc_run_ctrl.sv
module tsc_run_ctrl
    import tsc_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [WORD_W-1:0] cmd_data,
    output logic              frozen
);
    run_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RUNNING;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUNNING: if (cmd_wr && cmd_data == WORD_W'(CMD_PAUSE))  state_d = FROZEN;
            FROZEN:  if (cmd_wr && cmd_data == WORD_W'(CMD_RESUME)) state_d = RUNNING;
            default: state_d = RUNNING;
        endcase
    end

    always_comb begin
        frozen = (state_q == FROZEN);
    end

    a_r3_pause_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_data == WORD_W'(CMD_PAUSE)) |=> frozen);
    a_r3_resume_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_data == WORD_W'(CMD_RESUME)) |=> !frozen);
endmodule

// File: rtl/tsc_trim_unit.sv
module tsc_trim_unit
    import tsc_pkg::*;
#(
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned PERIOD_W = 28,
    parameter int unsigned MAG_W    = 3,
    parameter int unsigned NOM_STEP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frozen,
    input  logic              hold_wr,
    input  logic              hold_val,
    input  logic              word_wr,
    input  logic [WORD_W-1:0] word_data,
    output logic [WORD_W-1:0] word_q,
    output logic              hold_q,
    output logic              fire,
    output logic              corr_up,
    output logic [MAG_W-1:0]  corr_mag
);
    localparam int unsigned IVL_W   = PERIOD_W + 5;
    localparam int unsigned MAG_LSB = PERIOD_W;
    localparam int unsigned DIR_BIT = PERIOD_W + MAG_W;

    trim_state_e state_q, state_d;
    logic [IVL_W-1:0]    elapsed_q;
    logic [IVL_W-1:0]    elapsed_nx;
    logic [IVL_W-1:0]    interval_ns;
    logic [PERIOD_W-1:0] period_f;
    logic [MAG_W-1:0]    mag_f;
    logic                word_enabled;

    always_comb begin
        period_f     = word_q[PERIOD_W-1:0];
        mag_f        = word_q[MAG_LSB +: MAG_W];
        word_enabled = (mag_f != '0) && (period_f != '1);
        interval_ns  = {1'b0, period_f, 4'b0000} + IVL_W'(8);
        elapsed_nx   = elapsed_q + IVL_W'(NOM_STEP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRIM_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRIM_OFF:    if (hold_wr && hold_val) state_d = TRIM_HELD;
            TRIM_ACTIVE: if (hold_wr && hold_val) state_d = TRIM_HELD;
            TRIM_HELD:   if (hold_wr && !hold_val)
                             state_d = word_enabled ? TRIM_ACTIVE : TRIM_OFF;
            default:     state_d = TRIM_OFF;
        endcase
    end

    always_comb begin
        hold_q   = (state_q == TRIM_HELD);
        fire     = (state_q == TRIM_ACTIVE) && !frozen && (elapsed_nx >= interval_ns);
        corr_up  = word_q[DIR_BIT];
        corr_mag = mag_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     word_q <= '0;
        else if (word_wr && hold_q)     word_q <= word_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         elapsed_q <= '0;
        else if (state_q != TRIM_ACTIVE)    elapsed_q <= '0;
        else if (!frozen)                   elapsed_q <= fire ? '0 : elapsed_nx;
    end

    a_r5_word_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (word_wr && !hold_q) |=> (word_q == $past(word_q)));
    a_r7_elapsed_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRIM_ACTIVE) |-> (elapsed_q < interval_ns));
    a_r10_frozen_interval: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && state_q == TRIM_ACTIVE && !hold_wr) |=> $stable(elapsed_q));
endmodule

// File: rtl/tsc_time_core.sv
module tsc_time_core #(
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned MAG_W    = 3,
    parameter int unsigned NOM_STEP = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frozen,
    input  logic                ld_lo,
    input  logic                ld_hi,
    input  logic [WORD_W-1:0]   ld_data,
    input  logic                fire,
    input  logic                corr_up,
    input  logic [MAG_W-1:0]    corr_mag,
    input  logic                snap_en,
    output logic [2*WORD_W-1:0] time_q,
    output logic [WORD_W-1:0]   hi_snap
);
    localparam int unsigned TIME_W  = 2 * WORD_W;
    localparam int unsigned MAX_MAG = (1 << MAG_W) - 1;

    logic [TIME_W-1:0] step;

    always_comb begin
        step = TIME_W'(NOM_STEP);
        if (fire) begin
            if (corr_up) step = TIME_W'(NOM_STEP) + TIME_W'(corr_mag);
            else         step = TIME_W'(NOM_STEP) - TIME_W'(corr_mag);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            time_q <= '0;
        end else if (frozen) begin
            if (ld_lo) time_q[WORD_W-1:0]      <= ld_data;
            if (ld_hi) time_q[TIME_W-1:WORD_W] <= ld_data;
        end else begin
            time_q <= time_q + step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hi_snap <= '0;
        else if (snap_en) hi_snap <= time_q[TIME_W-1:WORD_W];
    end

    a_r3_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !ld_lo && !ld_hi) |=> (time_q == $past(time_q)));
    a_r7_step_window: assert property (@(posedge clk) disable iff (!rst_n)
        !frozen |=> ((time_q - $past(time_q)) <= TIME_W'(NOM_STEP + MAX_MAG)) &&
                    ((time_q - $past(time_q)) >= TIME_W'(NOM_STEP - MAX_MAG)));
    a_r9_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        snap_en |=> (hi_snap == $past(time_q[TIME_W-1:WORD_W])));
endmodule

// File: rtl/tsc_drift_clock.sv
module tsc_drift_clock
    import tsc_pkg::*;
#(
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned PERIOD_W = 28,
    parameter int unsigned MAG_W    = 3,
    parameter int unsigned NOM_STEP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int unsigned TIME_W = 2 * WORD_W;

    logic              frozen;
    logic [WORD_W-1:0] word_q;
    logic              hold_q;
    logic              fire;
    logic              corr_up;
    logic [MAG_W-1:0]  corr_mag;
    logic [TIME_W-1:0] time_q;
    logic [WORD_W-1:0] hi_snap;

    logic wr_ctrl, wr_lo, wr_hi, wr_word, wr_hold, snap_en;

    always_comb begin
        wr_ctrl = wr_en && (wr_addr == A_CONTROL);
        wr_lo   = wr_en && (wr_addr == A_LOAD_LOW);
        wr_hi   = wr_en && (wr_addr == A_LOAD_HIGH);
        wr_word = wr_en && (wr_addr == A_TRIM_WORD);
        wr_hold = wr_en && (wr_addr == A_TRIM_HOLD);
        snap_en = rd_en && (rd_addr == A_TIME_LOW);
    end

    tsc_run_ctrl #(.WORD_W(WORD_W)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (wr_ctrl),
        .cmd_data (wr_data),
        .frozen   (frozen)
    );

    tsc_trim_unit #(
        .WORD_W   (WORD_W),
        .PERIOD_W (PERIOD_W),
        .MAG_W    (MAG_W),
        .NOM_STEP (NOM_STEP)
    ) u_trim (
        .clk       (clk),
        .rst_n     (rst_n),
        .frozen    (frozen),
        .hold_wr   (wr_hold),
        .hold_val  (wr_data[0]),
        .word_wr   (wr_word),
        .word_data (wr_data),
        .word_q    (word_q),
        .hold_q    (hold_q),
        .fire      (fire),
        .corr_up   (corr_up),
        .corr_mag  (corr_mag)
    );

    tsc_time_core #(
        .WORD_W   (WORD_W),
        .MAG_W    (MAG_W),
        .NOM_STEP (NOM_STEP)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .frozen   (frozen),
        .ld_lo    (wr_lo),
        .ld_hi    (wr_hi),
        .ld_data  (wr_data),
        .fire     (fire),
        .corr_up  (corr_up),
        .corr_mag (corr_mag),
        .snap_en  (snap_en),
        .time_q   (time_q),
        .hi_snap  (hi_snap)
    );

    always_comb begin
        unique case (rd_addr)
            A_CONTROL:   rd_data = WORD_W'(frozen);
            A_TRIM_WORD: rd_data = word_q;
            A_TRIM_HOLD: rd_data = WORD_W'(hold_q);
            A_TIME_LOW:  rd_data = time_q[WORD_W-1:0];
            A_TIME_HIGH: rd_data = hi_snap;
            default:     rd_data = '0;
        endcase
    end

    a_r6_held_nominal: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !frozen) |=> (time_q == $past(time_q) + TIME_W'(NOM_STEP)));
    a_r4_running_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!frozen && (wr_lo || wr_hi) && !fire) |=> (time_q == $past(time_q) + TIME_W'(NOM_STEP)));
endmodule

// File: tb/tsc_drift_clock_test.sv
module tsc_drift_clock_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = 3'd5;
    logic [31:0] rd_data;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tsc_drift_clock uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // Reference model state
    longint unsigned m_time, m_el, m_ivl;
    logic [31:0] m_snap, m_cfg;
    bit m_paused, m_hold, m_en, m_fire;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_time = 0; m_snap = 0; m_cfg = 0; m_paused = 0; m_hold = 0; m_el = 0;
        end else begin
            if (rd_en && rd_addr == 3'd5) m_snap = m_time[63:32];
            m_en   = (m_cfg[30:28] != 0) && (m_cfg[27:0] != 28'hFFFFFFF);
            m_ivl  = longint'(m_cfg[27:0]) * 16 + 8;
            m_fire = 0;
            if (m_hold || !m_en) m_el = 0;
            else if (!m_paused) begin
                if (m_el + 8 >= m_ivl) begin m_fire = 1; m_el = 0; end
                else m_el = m_el + 8;
            end
            if (!m_paused) begin
                m_time = m_time + 8;
                if (m_fire) begin
                    if (m_cfg[31]) m_time = m_time + m_cfg[30:28];
                    else           m_time = m_time - m_cfg[30:28];
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: if (wr_data == 2) m_paused = 1; else if (wr_data == 4) m_paused = 0;
                    3'd1: if (m_paused && !m_fire) m_time[31:0] = wr_data;
                    3'd2: if (m_paused) m_time[63:32] = wr_data;
                    3'd3: if (m_hold) m_cfg = wr_data;
                    3'd4: m_hold = wr_data[0];
                    default: ;
                endcase
            end
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [31:0] exp;
            string tag;
            case (rd_addr)
                3'd0: begin exp = {31'd0, m_paused}; tag = "R3"; end
                3'd3: begin exp = m_cfg;             tag = "R5"; end
                3'd4: begin exp = {31'd0, m_hold};   tag = "R6"; end
                3'd5: begin exp = m_time[31:0];      tag = "R7"; end
                3'd6: begin exp = m_snap;            tag = "R9"; end
                default: begin exp = 0;              tag = "R1"; end
            endcase
            compared++;
            if (rd_data !== exp) begin
                mismatched++;
                $display("FAIL %s model addr=%0d actual=%h expected=%h", tag, rd_addr, rd_data, exp);
            end
        end
    end

    task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1; wr_en = 1; wr_addr = a; wr_data = d;
        @(posedge clk); #1; wr_en = 0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] v);
        @(posedge clk); #1; rd_en = 0; rd_addr = a;
        @(negedge clk); v = rd_data;
    endtask

    task automatic read_time(output longint unsigned t);
        logic [31:0] lo;
        @(posedge clk); #1; rd_en = 1; rd_addr = 3'd5;
        @(negedge clk); lo = rd_data;
        @(posedge clk); #1; rd_en = 0; rd_addr = 3'd6;
        @(negedge clk); t = {rd_data, lo};
    endtask

    task automatic gain_run(input string req, input logic [31:0] cfg, input longint unsigned exp_delta);
        longint unsigned t0, t1;
        wr(3'd4, 32'd1);
        wr(3'd3, cfg);
        wr(3'd4, 32'd0);
        read_time(t0);
        repeat (68) @(posedge clk);
        read_time(t1);
        chk(req, t1 - t0, exp_delta);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [31:0] v;
        longint unsigned t0, t1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R1 time", rd_data, 0);
        rd_reg(3'd0, v); chk("R1 control", v, 0);
        rd_reg(3'd3, v); chk("R1 trim word", v, 0);
        rd_reg(3'd4, v); chk("R1 hold", v, 0);

        // R2 nominal rate
        read_time(t0); repeat (18) @(posedge clk); read_time(t1);
        chk("R2 nominal", t1 - t0, 20 * 8);

        // R3 pause, ignored command, resume
        wr(3'd0, 32'd2);
        rd_reg(3'd0, v); chk("R3 frozen flag", v, 1);
        read_time(t0); repeat (5) @(posedge clk); read_time(t1);
        chk("R3 frozen stable", t1, t0);
        wr(3'd0, 32'd7);
        rd_reg(3'd0, v); chk("R3 other value ignored", v, 1);

        // R4 loads while frozen; R9 snapshot across a carry
        wr(3'd1, 32'hFFFF_FFE0);
        wr(3'd2, 32'd5);
        read_time(t0); chk("R4 load", t0, 64'h5_FFFF_FFE0);
        wr(3'd0, 32'd4);
        rd_reg(3'd0, v); chk("R3 resumed", v, 0);
        repeat (10) @(posedge clk);
        rd_reg(3'd6, v); chk("R9 captured high kept", v, 5);
        read_time(t0); chk("R9 fresh high", t0[63:32], 6);
        wr(3'd2, 32'hABC);
        read_time(t0); chk("R4 running load ignored", t0[63:32], 6);

        // R5 gated trim word write
        wr(3'd3, 32'h1234_5678);
        rd_reg(3'd3, v); chk("R5 write ignored without hold", v, 0);
        wr(3'd4, 32'd1);
        rd_reg(3'd4, v); chk("R6 hold reads 1", v, 1);
        wr(3'd3, 32'hD000_0003);
        rd_reg(3'd3, v); chk("R5 write accepted in hold", v, 32'hD000_0003);

        // R6 held: no trim even with strong word
        wr(3'd3, 32'hF000_0000);
        read_time(t0); repeat (68) @(posedge clk); read_time(t1);
        chk("R6 held nominal", t1 - t0, 560);

        // R7 gains and losses per interval
        gain_run("R7 add V=5 P=3", 32'hD000_0003, 70 * 8 + 10 * 5);
        gain_run("R7 sub V=3 P=3", 32'h3000_0003, 70 * 8 - 10 * 3);
        gain_run("R7 every cycle V=7 P=0", 32'hF000_0000, 70 * 15);

        // R10 frozen interval does not advance (model compare every clock)
        wr(3'd0, 32'd2); repeat (3) @(posedge clk); wr(3'd0, 32'd4);
        read_time(t0); repeat (68) @(posedge clk); read_time(t1);
        chk("R10 resumed cadence", t1 - t0, 70 * 15);

        // R8 disabled forms
        gain_run("R8 all-ones period", 32'hFFFF_FFFF, 560);
        gain_run("R8 zero magnitude", 32'h8000_0005, 560);
        wr(3'd4, 32'd1); wr(3'd3, 32'd0); wr(3'd4, 32'd0);
        read_time(t0); repeat (68) @(posedge clk); read_time(t1);
        chk("R8 zero word", t1 - t0, 560);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule